// File: doc/BRIEF.md
# External Bus Chip-Select and Wait-State Controller

This block sits between a small 8-bit processor core and the devices on its external bus: a program ROM, a data SRAM and a set of single-byte peripherals. For each access, the core gives a space flag (program or data), a 16-bit address and a read or write request. The controller latches the access and decodes it to one active-low device select. It drives active-low read and write strobes that line up with that select, and holds the core off with a ready handshake until the access is complete.

Each external access is stretched by a wait count of one to three cycles. Software sets this count by writing a small internal configuration register, which is itself reached through data space. Accesses that hit no device still complete, with the shortest stretch, so the core never hangs. A program-space access inside the top window that holds the interrupt vectors raises a flag beside the ROM select.

Top module: `ext_bus_cs_ctrl`

## Requirements
- R1: All selects (`rom_cs_n`, `ram_cs_n`, `per_cs_n`) and both strobes are high after reset and while no access is in progress, and at most one select is low in any cycle.
- R2: A program-space access (`cpu_space_prog`=1) at address 0100h or above asserts only `rom_cs_n`; a program-space access below 0100h asserts no select.
- R3: A data-space access (`cpu_space_prog`=0) at 0000h through 7FFFh asserts only `ram_cs_n`.
- R4: A data-space access at FF00h+i asserts only `per_cs_n[i]` (bit 0 at FF00h, bit 1 at FF01h); a program-space access to the same addresses selects the ROM and never a peripheral.
- R5: A data-space access outside the SRAM range, the peripheral bytes and the configuration address asserts no select and no strobe, and completes after 2 cycles (one wait).
- R6: The wait configuration register sits at data address FF7Fh, bits [1:0]. It resets to 3. A write changes the count for all later accesses. A read returns the count in `cpu_rdata[1:0]` with zeros above. Neither a read nor a write drives any select or strobe.
- R7: A mapped access holds its select low for W+1 consecutive cycles, where W is the configured count and a stored 0 is taken as 1. `cpu_ready` is high for exactly the last of those cycles and low otherwise.
- R8: `bus_rd_n` (for a read) or `bus_wr_n` (for a write) is low in exactly the cycles in which a select is low. When read and write are requested together, the access is a read.
- R9: `vec_win` is high throughout a program-space access at FF80h through FFFFh, which also selects the ROM, and is low otherwise.
- R10: During an access, `bus_addr` and `bus_wdata` carry the address and data latched from the core. In the ready cycle of an external read, `cpu_rdata` equals `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_rd | input | 1 | Read request, held until ready |
| cpu_req_wr | input | 1 | Write request, held until ready |
| cpu_space_prog | input | 1 | 1 = program space, 0 = data space |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data from core |
| cpu_rdata | output | 8 | Read data to core |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_addr | output | 16 | Latched external address |
| bus_wdata | output | 8 | Latched external write data |
| bus_rdata | input | 8 | Read data from devices |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| rom_cs_n | output | 1 | Program ROM select, active low |
| ram_cs_n | output | 1 | Data SRAM select, active low |
| per_cs_n | output | 2 | Peripheral selects, active low |
| vec_win | output | 1 | Vector-window access flag |

## Verification
The decoder is tested with addresses on both sides of every window edge (00FFh/0100h, 7FFFh/8000h, FEFFh/FF00h/FF01h/FF02h, FF7Fh/FF80h), each in both spaces. This separates a space-flag error from an address-compare error. The stretch is measured after the count is programmed to 0, 1, 2 and 3, so an error in the zero-to-one rule or an off-by-one in the counter shows up as a length mismatch. Random mixes of reads, writes, simultaneous requests and configuration writes check that the strobe follows the access kind, and that a new count takes effect only on later accesses.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  // Effective wait count: a stored zero stretches like one.
  function automatic logic [1:0] eff_wait(input logic [1:0] raw);
    return (raw == 2'd0) ? 2'd1 : raw;
  endfunction
endpackage

// File: rtl/ebc_decode.sv
module ebc_decode #(
  parameter int AW = 16,
  parameter int NUM_PER = 2,
  parameter logic [AW-1:0] ROM_BASE  = 16'h0100,
  parameter logic [AW-1:0] RAM_TOP   = 16'h7FFF,
  parameter logic [AW-1:0] PER_BASE  = 16'hFF00,
  parameter logic [AW-1:0] VEC_BASE  = 16'hFF80,
  parameter logic [AW-1:0] WCFG_ADDR = 16'hFF7F,
  localparam int NSEL = 2 + NUM_PER
) (
  input  logic          prog,
  input  logic [AW-1:0] addr,
  output logic [NSEL-1:0] hit,
  output logic          wcfg_hit,
  output logic          vec_hit
);
  logic               rom_hit;
  logic               ram_hit;
  logic [NUM_PER-1:0] per_hit;

  assign rom_hit  = prog && (addr >= ROM_BASE);
  assign ram_hit  = !prog && (addr <= RAM_TOP);
  assign wcfg_hit = !prog && (addr == WCFG_ADDR);
  assign vec_hit  = prog && (addr >= VEC_BASE);

  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    localparam logic [AW-1:0] PADDR = PER_BASE + AW'(i);
    assign per_hit[i] = !prog && (addr == PADDR);
  end

  assign hit = {per_hit, ram_hit, rom_hit};
endmodule

// File: rtl/ebc_wait_cfg.sv
module ebc_wait_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic [1:0] raw_q,
  output logic [1:0] eff
);
  import ebc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 2'd3;
    else if (we) raw_q <= wdata;
  end

  assign eff = eff_wait(raw_q);
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NSEL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_rd,
  input  logic            req_wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSEL-1:0] hit,
  input  logic            wcfg_hit,
  input  logic            vec_hit,
  input  logic [1:0]      eff,
  output logic            busy,
  output logic            last,
  output logic [NSEL-1:0] sel_q,
  output logic            rd_q,
  output logic            wcfg_q,
  output logic            vec_q,
  output logic [AW-1:0]   addr_q,
  output logic [DW-1:0]   wdata_q
);
  logic [1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= 2'd0;
      sel_q   <= '0;
      rd_q    <= 1'b0;
      wcfg_q  <= 1'b0;
      vec_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy) begin
      if (req_rd || req_wr) begin
        busy    <= 1'b1;
        sel_q   <= hit;
        rd_q    <= req_rd;
        wcfg_q  <= wcfg_hit;
        vec_q   <= vec_hit;
        addr_q  <= addr;
        wdata_q <= wdata;
        cnt     <= (|hit) ? eff : 2'd1;
      end
    end else if (cnt == 2'd0) begin
      busy   <= 1'b0;
      sel_q  <= '0;
      wcfg_q <= 1'b0;
      vec_q  <= 1'b0;
    end else begin
      cnt <= cnt - 2'd1;
    end
  end

  assign last = busy && (cnt == 2'd0);
endmodule

// File: rtl/ext_bus_cs_ctrl.sv
module ext_bus_cs_ctrl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NUM_PER = 2,
  parameter logic [AW-1:0] ROM_BASE  = 16'h0100,
  parameter logic [AW-1:0] RAM_TOP   = 16'h7FFF,
  parameter logic [AW-1:0] PER_BASE  = 16'hFF00,
  parameter logic [AW-1:0] VEC_BASE  = 16'hFF80,
  parameter logic [AW-1:0] WCFG_ADDR = 16'hFF7F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_rd,
  input  logic               cpu_req_wr,
  input  logic               cpu_space_prog,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_ready,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               rom_cs_n,
  output logic               ram_cs_n,
  output logic [NUM_PER-1:0] per_cs_n,
  output logic               vec_win
);
  localparam int NSEL = 2 + NUM_PER;

  logic [NSEL-1:0] hit, sel_q;
  logic            wcfg_hit, vec_hit;
  logic [1:0]      wait_raw, wait_eff;
  logic            acc_busy, acc_last, rd_q, wcfg_q, vec_q;
  logic            ext_active, cfg_we;

  ebc_decode #(
    .AW(AW), .NUM_PER(NUM_PER), .ROM_BASE(ROM_BASE), .RAM_TOP(RAM_TOP),
    .PER_BASE(PER_BASE), .VEC_BASE(VEC_BASE), .WCFG_ADDR(WCFG_ADDR)
  ) u_dec (
    .prog(cpu_space_prog), .addr(cpu_addr), .hit(hit),
    .wcfg_hit(wcfg_hit), .vec_hit(vec_hit)
  );

  ebc_seq #(.AW(AW), .DW(DW), .NSEL(NSEL)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_rd(cpu_req_rd), .req_wr(cpu_req_wr),
    .addr(cpu_addr), .wdata(cpu_wdata), .hit(hit), .wcfg_hit(wcfg_hit),
    .vec_hit(vec_hit), .eff(wait_eff), .busy(acc_busy), .last(acc_last),
    .sel_q(sel_q), .rd_q(rd_q), .wcfg_q(wcfg_q), .vec_q(vec_q),
    .addr_q(bus_addr), .wdata_q(bus_wdata)
  );

  assign cfg_we = acc_last && wcfg_q && !rd_q;

  ebc_wait_cfg u_wcfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(bus_wdata[1:0]),
    .raw_q(wait_raw), .eff(wait_eff)
  );

  assign ext_active = acc_busy && (|sel_q);
  assign rom_cs_n   = !(acc_busy && sel_q[0]);
  assign ram_cs_n   = !(acc_busy && sel_q[1]);
  assign per_cs_n   = ~({NUM_PER{acc_busy}} & sel_q[NSEL-1:2]);
  assign bus_rd_n   = !(ext_active && rd_q);
  assign bus_wr_n   = !(ext_active && !rd_q);
  assign cpu_ready  = acc_last;
  assign vec_win    = acc_busy && vec_q;
  assign cpu_rdata  = (acc_busy && wcfg_q) ? {{(DW-2){1'b0}}, wait_raw} : bus_rdata;
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int AW = 16,
  parameter int NUM_PER = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rom_cs_n,
  input logic               ram_cs_n,
  input logic [NUM_PER-1:0] per_cs_n,
  input logic               bus_rd_n,
  input logic               bus_wr_n,
  input logic               cpu_ready,
  input logic               vec_win,
  input logic [AW-1:0]      bus_addr,
  input logic               acc_busy
);
  logic [NUM_PER+1:0] sel_low;
  logic               any_sel;
  logic [3:0]         run;

  assign sel_low = ~{per_cs_n, ram_cs_n, rom_cs_n};
  assign any_sel = |sel_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 4'd0;
    else if (acc_busy && !cpu_ready) run <= run + 4'd1;
    else run <= 4'd0;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_low) <= 1); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_busy |-> (!any_sel && bus_rd_n && bus_wr_n && !cpu_ready)); // R1
  AST_RAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> !bus_addr[AW-1]); // R3
  AST_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (per_cs_n != '1) |-> (bus_addr[AW-1:8] == '1)); // R4
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R7
  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (run >= 4'd1 && run <= 4'd3)); // R7
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy && !cpu_ready) |=> $stable(sel_low)); // R7
  AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel == (!bus_rd_n || !bus_wr_n)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R8
  AST_VEC_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    vec_win |-> !rom_cs_n); // R9
endmodule

bind ext_bus_cs_ctrl ebc_chk #(.AW(AW), .NUM_PER(NUM_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
  .per_cs_n(per_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .cpu_ready(cpu_ready), .vec_win(vec_win), .bus_addr(bus_addr),
  .acc_busy(acc_busy)
);

// File: tb/sim_ext_bus_cs_ctrl.sv
`timescale 1ns/1ps
module sim_ext_bus_cs_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd = 1'b0, req_wr = 1'b0, prog = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, bus_wdata, bus_rdata;
  logic        ready, rd_n, wr_n, rom_n, ram_n, vec;
  logic [15:0] bus_addr;
  logic [1:0]  per_n;

  int checks = 0;
  int fails = 0;
  int wmodel = 3;

  always #2.5 clk = ~clk;
  assign bus_rdata = bus_addr[7:0] ^ 8'h5A;

  ext_bus_cs_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req_rd(req_rd), .cpu_req_wr(req_wr),
    .cpu_space_prog(prog), .cpu_addr(addr), .cpu_wdata(wdata),
    .cpu_rdata(rdata), .cpu_ready(ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_n(rd_n),
    .bus_wr_n(wr_n), .rom_cs_n(rom_n), .ram_cs_n(ram_n), .per_cs_n(per_n),
    .vec_win(vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Device code: 0 none, 1 ROM, 2 SRAM, 3+i peripheral i, 9 wait register.
  function automatic int exp_dev(input logic p, input logic [15:0] a);
    if (p) return (a >= 16'h0100) ? 1 : 0;
    if (a <= 16'h7FFF) return 2;
    if (a == 16'hFF00) return 3;
    if (a == 16'hFF01) return 4;
    if (a == 16'hFF7F) return 9;
    return 0;
  endfunction

  function automatic int exp_len(input int dev, input int w);
    if (dev == 0 || dev == 9) return 2;
    return ((w == 0) ? 1 : w) + 1;
  endfunction

  function automatic string dev_tag(input int dev, input logic p);
    if (dev == 1) return "R2";
    if (dev == 2) return "R3";
    if (dev == 3 || dev == 4) return "R4";
    if (dev == 9) return "R6";
    return p ? "R2" : "R5";
  endfunction

  function automatic int obs_dev();
    int n = 0;
    int d = 0;
    if (!rom_n) begin n++; d = 1; end
    if (!ram_n) begin n++; d = 2; end
    if (!per_n[0]) begin n++; d = 3; end
    if (!per_n[1]) begin n++; d = 4; end
    return (n > 1) ? 99 : d;
  endfunction

  task automatic access(input logic p, input logic [15:0] a, input logic r,
                        input logic w, input logic [7:0] d);
    int dev = exp_dev(p, a);
    int mapped = (dev != 0 && dev != 9);
    int first_dev = -1;
    int n = 0;
    int low_cnt = 0;
    int strobe_bad = 0;
    int vec_bad = 0;
    int addr_bad = 0;
    int rd_val = 0;
    logic is_rd = r;
    logic exp_vec = p && (a >= 16'hFF80);
    @(negedge clk);
    prog = p; addr = a; req_rd = r; req_wr = w; wdata = d;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      n++;
      if (first_dev < 0) first_dev = obs_dev();
      if (obs_dev() != 0) low_cnt++;
      if ((!rd_n) != (is_rd && obs_dev() != 0)) strobe_bad++;
      if ((!wr_n) != (!is_rd && obs_dev() != 0)) strobe_bad++;
      if (vec != exp_vec) vec_bad++;
      if (bus_addr != a || (!is_rd && bus_wdata != d)) addr_bad++;
      if (ready) begin rd_val = rdata; break; end
    end
    req_rd = 1'b0; req_wr = 1'b0;
    check({dev_tag(dev, p), " select"}, first_dev, mapped ? dev : 0);
    check(mapped ? "R7 stretch" : "R5 stretch", n, exp_len(dev, wmodel));
    check(mapped ? "R7 select length" : "R5 no select", low_cnt, mapped ? n : 0);
    check("R8 strobes", strobe_bad, 0);
    check("R9 vector flag", vec_bad, 0);
    check("R10 bus address/data", addr_bad, 0);
    if (is_rd && dev == 9) check("R6 readback", rd_val, wmodel);
    else if (is_rd && mapped) check("R10 read data", rd_val, a[7:0] ^ 8'h5A);
    if (!is_rd && dev == 9) wmodel = d[1:0];
    @(negedge clk);
    check("R1 idle quiet", {rom_n, ram_n, per_n, rd_n, wr_n, ready}, 7'b1111110);
  endtask

  function automatic logic [15:0] pick_addr(input int sel);
    case (sel)
      0: return 16'($urandom % 16'h8000);
      1: return 16'hFF00 + 16'($urandom % 2);
      2: return 16'hFF7F;
      3: return 16'h8000 + 16'($urandom % 16'h7F00);
      4: return 16'hFF80 + 16'($urandom % 128);
      5: return 16'($urandom % 16'h0200);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset state", {rom_n, ram_n, per_n, rd_n, wr_n, ready, vec}, 8'b11111100);
    rst_n = 1'b1;
    // R6 reset value, then each programmed count
    access(1'b0, 16'hFF7F, 1'b1, 1'b0, 8'h00);
    access(1'b0, 16'h1234, 1'b1, 1'b0, 8'h00);
    for (int w = 0; w < 4; w++) begin
      access(1'b0, 16'hFF7F, 1'b0, 1'b1, 8'hF0 | 8'(w));
      access(1'b0, 16'hFF7F, 1'b1, 1'b0, 8'h00);
      access(1'b0, 16'h7FFF, 1'b0, 1'b1, 8'hA5);
      access(1'b1, 16'h0100, 1'b1, 1'b0, 8'h00);
    end
    // window edges
    access(1'b1, 16'h00FF, 1'b1, 1'b0, 8'h00);
    access(1'b0, 16'h8000, 1'b1, 1'b0, 8'h00);
    access(1'b0, 16'hFEFF, 1'b0, 1'b1, 8'h11);
    access(1'b0, 16'hFF00, 1'b0, 1'b1, 8'h22);
    access(1'b0, 16'hFF01, 1'b1, 1'b0, 8'h00);
    access(1'b0, 16'hFF02, 1'b1, 1'b0, 8'h00);
    access(1'b1, 16'hFF00, 1'b1, 1'b0, 8'h00);
    access(1'b1, 16'hFF7F, 1'b1, 1'b0, 8'h00);
    access(1'b1, 16'hFF80, 1'b1, 1'b0, 8'h00);
    access(1'b1, 16'hFFFF, 1'b1, 1'b0, 8'h00);
    access(1'b0, 16'hFF80, 1'b1, 1'b0, 8'h00);
    // R8 simultaneous requests resolve as a read
    access(1'b0, 16'h0040, 1'b1, 1'b1, 8'h33);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 8;
      logic p = (sel == 4 || sel == 5) ? 1'b1 : ((sel == 7) ? 1'($urandom) : 1'b0);
      int kind = $urandom % 3;
      access(p, pick_addr(sel), kind != 1, kind != 0, 8'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule